// File: doc/BRIEF.md
# Legacy BIOS Region Attribute Router

This block watches every memory request and decides where it goes when it lands in the legacy window from 0C0000h up to, but not including, 100000h. The window is split into thirteen segments. Each segment holds its own read-enable bit and write-enable bit. A read is sent to main DRAM only when the segment's read-enable is set, and a write only when its write-enable is set. Any other access inside the window goes to the downstream I/O port with its address unchanged. Because reads and writes are steered separately, firmware can copy its ROM image into DRAM: it first routes writes to DRAM while reads still come from the port, then switches reads over as well.

Traffic that skips cache snooping and comes from the PCI Express side or from the downstream port always goes to DRAM, whatever the attribute bits say. An implicit writeback whose resolved target is the downstream port cannot be serviced there. The block drops such a request, marks the response as a hazard and sets an error flag that stays set until reset. Requests outside the window are answered as not claimed.

Attribute bits are written through a small select/data/strobe port. Each request gets one response, one cycle later.

Top module: `legacy_window_router`

## Requirements
- R1: A request whose address is below 0C0000h or at or above 100000h gets a response with target code 0 (not claimed), with rsp_hazard low, and it never sets err_flag, even when req_iwb is high.
- R2: Segment index: an address from 0C0000h to 0EFFFFh belongs to segment (address − 0C0000h) / 4000h, which gives indices 0 to 11 with 16 KB each. An address from 0F0000h to 0FFFFFh belongs to segment 12, which covers 64 KB. The attributes of one segment have no effect on addresses in any other segment.
- R3: After reset, the attribute bits of all thirteen segments are clear and err_flag is low. Every read or write into the window therefore resolves to the downstream port (target code 2).
- R4: A read (req_write=0) into a segment resolves to DRAM (target code 1) when that segment's read-enable bit (cfg_wdata bit 0) is set. Otherwise it resolves to the port (code 2).
- R5: A write (req_write=1) resolves to DRAM when the segment's write-enable bit (cfg_wdata bit 1) is set, and to the port otherwise. The write-enable bit is independent of the read-enable bit.
- R6: A request with req_nosnoop=1 and req_origin equal to 1 (PCI Express side) or 2 (downstream port) that falls inside the window resolves to DRAM whatever the attribute bits are. A request with req_nosnoop=1 from origin 0 (processor) follows the attribute bits.
- R7: When req_iwb=1 and the request would resolve to the port, the response carries target code 0 and rsp_hazard=1, and err_flag rises in the same cycle and stays high until reset. When req_iwb=1 and the request resolves to DRAM, the response is normal and no error is raised.
- R8: A pulse on cfg_we loads cfg_wdata into the segment chosen by cfg_sel when cfg_sel is 0 to 12. A cfg_sel of 13 to 15 changes nothing. A request in the same cycle as a write is steered with the old values, and the next request sees the new ones.
- R9: rsp_valid rises exactly one cycle after a request is accepted and stays low in cycles without a request. rsp_addr equals the request address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_sel | input | 4 | Segment index to write |
| cfg_wdata | input | 2 | Bit 1 write-enable, bit 0 read-enable |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_nosnoop | input | 1 | Request skips cache snooping |
| req_iwb | input | 1 | Request carries an implicit writeback |
| req_origin | input | 2 | 0 processor, 1 PCI Express side, 2 downstream port |
| rsp_valid | output | 1 | Response present |
| rsp_tgt | output | 2 | 0 not claimed or dropped, 1 DRAM, 2 downstream port |
| rsp_addr | output | ADDR_W | Forwarded address, unchanged |
| rsp_hazard | output | 1 | Request dropped because of an implicit writeback to the port |
| err_flag | output | 1 | Sticky hazard error |

## Verification
The bench enables one segment at a time and reads at both its first and last byte, then at the first byte of the next segment. A decoder that folds the top 64 KB into 16 KB pieces, or that is off by one at a boundary, would send one of these reads to the wrong target. It sets read-enable and write-enable separately, so a router that applies one bit to both directions is caught. It also issues non-snooped traffic from every origin, which catches a bypass that is too wide (processor traffic) or too narrow (downstream traffic). It writes an attribute in the same cycle as a request, which catches a design that uses the new value too early. Finally, it sends implicit writebacks outside the window and on the bypass path before sending one that is a real hazard, so a flag that fires on the wrong cases, or that clears itself, shows up.

// File: rtl/lwr_pkg.sv
package lwr_pkg;

  localparam int unsigned NSEG   = 13;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned WIN_LO = 32'h000C_0000;
  localparam int unsigned WIN_HI = 32'h0010_0000;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DRAM = 2'd1,
    TGT_PORT = 2'd2
  } tgt_e;

  localparam logic [1:0] ORG_CPU  = 2'd0;
  localparam logic [1:0] ORG_PCIE = 2'd1;
  localparam logic [1:0] ORG_DOWN = 2'd2;

  // 16 KB slices below 0F0000h, one 64 KB slice on top
  function automatic logic [SEL_W-1:0] seg_index(input logic [19:0] low);
    if (low[17:16] == 2'b11) return SEL_W'(NSEG - 1);
    return {low[17:14]};
  endfunction

  function automatic logic may_bypass(input logic nosnoop, input logic [1:0] origin);
    return nosnoop && ((origin == ORG_PCIE) || (origin == ORG_DOWN));
  endfunction

endpackage

// File: rtl/lwr_decode.sv
module lwr_decode
  import lwr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [SEL_W-1:0]  seg
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_HI);

  assign in_win = (addr >= LO) && (addr < HI);
  assign seg    = seg_index(addr[19:0]);

  AST_SEG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (seg < SEL_W'(NSEG))) else $error("segment out of range"); // R2
endmodule

// File: rtl/lwr_attr_regs.sv
module lwr_attr_regs
  import lwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [1:0]       cfg_wdata,
  output logic [NSEG-1:0]  rd_vec,
  output logic [NSEG-1:0]  wr_vec
);
  logic sel_ok;
  assign sel_ok = cfg_sel < SEL_W'(NSEG);

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic hit;
    assign hit = cfg_we && sel_ok && (cfg_sel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_vec[i] <= 1'b0;
        wr_vec[i] <= 1'b0;
      end else if (hit) begin
        rd_vec[i] <= cfg_wdata[0];
        wr_vec[i] <= cfg_wdata[1];
      end
    end
  end

  AST_CFG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && sel_ok) |=> (rd_vec[$past(cfg_sel)] == $past(cfg_wdata[0]))
                        && (wr_vec[$past(cfg_sel)] == $past(cfg_wdata[1])))
    else $error("attribute write lost"); // R8
  AST_CFG_BAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !sel_ok) |=> ($stable(rd_vec) && $stable(wr_vec)))
    else $error("out-of-range select changed state"); // R8
endmodule

// File: rtl/lwr_steer.sv
module lwr_steer
  import lwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_win,
  input  logic [SEL_W-1:0] seg,
  input  logic             is_write,
  input  logic             nosnoop,
  input  logic             iwb,
  input  logic [1:0]       origin,
  input  logic [NSEG-1:0]  rd_vec,
  input  logic [NSEG-1:0]  wr_vec,
  output tgt_e             tgt,
  output logic             hazard
);
  logic attr_on, bypass;
  tgt_e resolved;

  always_comb begin
    attr_on = 1'b0;
    if (seg < SEL_W'(NSEG))
      attr_on = is_write ? wr_vec[seg] : rd_vec[seg];
  end

  assign bypass = may_bypass(nosnoop, origin);

  always_comb begin
    if (!in_win)                 resolved = TGT_NONE;
    else if (bypass || attr_on)  resolved = TGT_DRAM;
    else                         resolved = TGT_PORT;
  end

  assign hazard = iwb && (resolved == TGT_PORT);
  assign tgt    = hazard ? TGT_NONE : resolved;

  AST_BYPASS_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && bypass) |-> (tgt == TGT_DRAM)) else $error("bypass missed"); // R6
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (!hazard && tgt == TGT_NONE)) else $error("outside claimed"); // R1
endmodule

// File: rtl/legacy_window_router.sv
module legacy_window_router
  import lwr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [1:0]        cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_nosnoop,
  input  logic              req_iwb,
  input  logic [1:0]        req_origin,
  output logic              rsp_valid,
  output logic [1:0]        rsp_tgt,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_hazard,
  output logic              err_flag
);
  logic             in_win;
  logic [SEL_W-1:0] seg;
  logic [NSEG-1:0]  rd_vec, wr_vec;
  tgt_e             nxt_tgt;
  logic             nxt_haz;

  lwr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .in_win(in_win), .seg(seg));

  lwr_attr_regs u_attr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_vec(rd_vec), .wr_vec(wr_vec));

  lwr_steer u_steer (
    .clk(clk), .rst_n(rst_n), .in_win(in_win), .seg(seg),
    .is_write(req_write), .nosnoop(req_nosnoop), .iwb(req_iwb),
    .origin(req_origin), .rd_vec(rd_vec), .wr_vec(wr_vec),
    .tgt(nxt_tgt), .hazard(nxt_haz));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_tgt    <= 2'd0;
      rsp_addr   <= '0;
      rsp_hazard <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_tgt    <= req_valid ? nxt_tgt : 2'd0;
      rsp_addr   <= req_valid ? req_addr : rsp_addr;
      rsp_hazard <= req_valid && nxt_haz;
      if (req_valid && nxt_haz) err_flag <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag) else $error("error flag cleared"); // R7
  AST_HAZ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hazard |-> (rsp_tgt == 2'd0 && err_flag)) else $error("hazard forwarded"); // R7
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid) else $error("response without request"); // R9
  AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_addr == $past(req_addr))) else $error("address altered"); // R9
endmodule

// File: tb/sim_legacy_window_router.sv
module sim_legacy_window_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [1:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0, req_nosnoop = 1'b0, req_iwb = 1'b0;
  logic [1:0]  req_origin = '0;
  logic        rsp_valid, rsp_hazard, err_flag;
  logic [1:0]  rsp_tgt;
  logic [31:0] rsp_addr;
  int total = 0, bad = 0;
  bit done = 1'b0;

  localparam logic [1:0] NONE = 2'd0, DRAM = 2'd1, PORT = 2'd2;

  always #5 clk = ~clk;

  legacy_window_router #(.ADDR_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_nosnoop(req_nosnoop), .req_iwb(req_iwb), .req_origin(req_origin),
    .rsp_valid(rsp_valid), .rsp_tgt(rsp_tgt), .rsp_addr(rsp_addr),
    .rsp_hazard(rsp_hazard), .err_flag(err_flag));

  function automatic logic [31:0] seg_lo(input int i);
    return (i < 12) ? 32'h000C_0000 + 32'(i) * 32'h4000 : 32'h000F_0000;
  endfunction
  function automatic logic [31:0] seg_hi(input int i);
    return (i < 12) ? seg_lo(i) + 32'h3FFF : 32'h000F_FFFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] a, input logic w, input logic ns, input logic iw,
                      input logic [1:0] org, input logic [1:0] et, input logic eh, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_nosnoop = ns; req_iwb = iw; req_origin = org;
    @(posedge clk); #1;
    req_valid = 1'b0; req_iwb = 1'b0; req_nosnoop = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " valid R9"}, 32'(rsp_valid), 1);
    chk(rsp_tgt == et, {tag, " target"}, 32'(rsp_tgt), 32'(et));
    chk(rsp_hazard == eh, {tag, " hazard"}, 32'(rsp_hazard), 32'(eh));
    chk(rsp_addr == a, {tag, " addr R9"}, rsp_addr, a);
  endtask

  task automatic t_reset;  // R3
    @(negedge clk);
    chk(err_flag == 1'b0, "R3 err after reset", 32'(err_flag), 0);
    chk(rsp_valid == 1'b0, "R9 idle no rsp", 32'(rsp_valid), 0);
    for (int i = 0; i < 13; i++) begin
      send(seg_lo(i), 1'b0, 1'b0, 1'b0, 2'd0, PORT, 1'b0, "R3 read default");
      send(seg_hi(i), 1'b1, 1'b0, 1'b0, 2'd0, PORT, 1'b0, "R3 write default");
    end
  endtask

  task automatic t_outside;  // R1
    send(32'h000B_FFFF, 1'b0, 1'b0, 1'b1, 2'd0, NONE, 1'b0, "R1 below window");
    send(32'h0010_0000, 1'b1, 1'b0, 1'b1, 2'd0, NONE, 1'b0, "R1 above window");
    send(32'h8000_0000, 1'b0, 1'b0, 1'b1, 2'd2, NONE, 1'b0, "R1 high address");
    @(negedge clk);
    chk(err_flag == 1'b0, "R1 no error outside", 32'(err_flag), 0);
  endtask

  task automatic t_segments;  // R2 R4
    for (int i = 0; i < 13; i++) begin
      cfg(i, 2'b01);
      send(seg_lo(i), 1'b0, 1'b0, 1'b0, 2'd0, DRAM, 1'b0, "R4 read first byte");
      send(seg_hi(i), 1'b0, 1'b0, 1'b0, 2'd0, DRAM, 1'b0, "R2 read last byte");
      if (i < 12)
        send(seg_hi(i) + 1, 1'b0, 1'b0, 1'b0, 2'd0, PORT, 1'b0, "R2 next segment");
      if (i > 0)
        send(seg_lo(i) - 1, 1'b0, 1'b0, 1'b0, 2'd0, PORT, 1'b0, "R2 prev segment");
      send(seg_lo(i), 1'b1, 1'b0, 1'b0, 2'd0, PORT, 1'b0, "R5 write blocked by read-only");
      cfg(i, 2'b00);
    end
  endtask

  task automatic t_write_only;  // R5
    cfg(5, 2'b10);
    send(seg_lo(5) + 32'h100, 1'b1, 1'b0, 1'b0, 2'd0, DRAM, 1'b0, "R5 write enabled");
    send(seg_lo(5) + 32'h100, 1'b0, 1'b0, 1'b0, 2'd0, PORT, 1'b0, "R5 read still port");
    cfg(5, 2'b11);
    send(seg_lo(5), 1'b0, 1'b0, 1'b0, 2'd0, DRAM, 1'b0, "R4 read both set");
    cfg(5, 2'b00);
  endtask

  task automatic t_bypass;  // R6
    send(32'h000F_8000, 1'b0, 1'b1, 1'b0, 2'd1, DRAM, 1'b0, "R6 pcie nosnoop read");
    send(32'h000E_4000, 1'b1, 1'b1, 1'b0, 2'd2, DRAM, 1'b0, "R6 downstream nosnoop write");
    send(32'h000E_4000, 1'b0, 1'b1, 1'b0, 2'd0, PORT, 1'b0, "R6 cpu nosnoop follows attrs");
    send(32'h000E_4000, 1'b0, 1'b0, 1'b0, 2'd1, PORT, 1'b0, "R6 pcie snooped follows attrs");
  endtask

  task automatic t_cfg_rules;  // R8
    for (int s = 13; s < 16; s++) cfg(s, 2'b11);
    for (int i = 0; i < 13; i++)
      send(seg_lo(i), 1'b0, 1'b0, 1'b0, 2'd0, PORT, 1'b0, "R8 bad select ignored");
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'd0; cfg_wdata = 2'b01;
    req_valid = 1'b1; req_addr = 32'h000C_0000; req_write = 1'b0; req_origin = 2'd0;
    @(posedge clk); #1;
    cfg_we = 1'b0; req_valid = 1'b0;
    chk(rsp_tgt == PORT, "R8 same-cycle uses old", 32'(rsp_tgt), 32'(PORT));
    send(32'h000C_0000, 1'b0, 1'b0, 1'b0, 2'd0, DRAM, 1'b0, "R8 next uses new");
    cfg(0, 2'b00);
  endtask

  task automatic t_hazard;  // R7
    send(32'h000F_0000, 1'b0, 1'b1, 1'b1, 2'd2, DRAM, 1'b0, "R7 iwb on bypass ok");
    cfg(3, 2'b01);
    send(seg_lo(3), 1'b0, 1'b0, 1'b1, 2'd0, DRAM, 1'b0, "R7 iwb to dram ok");
    @(negedge clk);
    chk(err_flag == 1'b0, "R7 no error before hazard", 32'(err_flag), 0);
    send(32'h000F_0000, 1'b0, 1'b0, 1'b1, 2'd2, NONE, 1'b1, "R7 hazard dropped");
    chk(err_flag == 1'b1, "R7 error raised", 32'(err_flag), 1);
    send(seg_lo(3), 1'b0, 1'b0, 1'b0, 2'd0, DRAM, 1'b0, "R7 normal after hazard");
    repeat (3) @(negedge clk);
    chk(err_flag == 1'b1, "R7 error sticky", 32'(err_flag), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_outside();
    t_segments();
    t_write_only();
    t_bypass();
    t_cfg_rules();
    t_hazard();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule